// File: doc/BRIEF.md
# Per-Processor Interrupt Pending Bank

This block holds the interrupt pending word of one processor. Software reaches it through a 16-byte window of 32-bit words. The byte address is shifted right by two to give the word index. Word 0 returns the pending word. Word 1 clears software bits wherever a one is written. Word 2 sets software bits wherever a one is written. Only the upper fifteen bits, 17 to 31, can be written by software.

Hardware also updates the bank directly through two event inputs, each of which sets or clears one level bit (1 to 15):

- a device input, which carries its own 4-bit level and has already been routed to this processor;
- the processor's local timer, whose level is a parameter.

The software bits, shifted down by sixteen, drive the processor's 16-wide priority-level vector. Routing and global masking are done elsewhere.

Top module: `pcpu_irq_bank`

## Requirements
- R1: A synchronous active-high reset clears every pending bit, so a read of word 0 returns 0 and `lvl_vec` is 0 after reset.
- R2: Reads are combinational. The word index is `bus_addr[3:2]`. Index 0 returns the pending word, and indices 1, 2 and 3 return zero.
- R3: A write to word index 1 clears, at the next clock edge, every pending bit that is one in `bus_wdata & 32'hFFFE0000`.
- R4: A write to word index 1 with `bus_wdata[14]` set also clears pending bit 31, even if `bus_wdata[31]` is zero.
- R5: A write to word index 2 sets, at the next clock edge, every pending bit that is one in `bus_wdata & 32'hFFFE0000`. Bits 0 to 16 are never changed by a write.
- R6: Writes to word indices 0 and 3 leave the pending word unchanged. Address bits 1:0 are ignored. A write takes effect only in a cycle where `bus_wr` is high.
- R7: `lvl_vec[15:1]` equals pending bits 31:17, and `lvl_vec[0]` is always 0.
- R8: A `dev_evt` cycle with `dev_on` high sets pending bit `dev_lvl`, and with `dev_on` low clears it. A level of 0 changes nothing.
- R9: A `tmr_evt` cycle with `tmr_on` high sets pending bit TMR_LEVEL (default 14), and with `tmr_on` low clears it.
- R10: When one hardware source clears a level bit and the other sets the same bit in the same cycle, the set wins.
- R11: A bus write and hardware events in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address inside the window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| dev_evt | input | 1 | Device level event |
| dev_lvl | input | 4 | Level targeted by the device event |
| dev_on | input | 1 | 1 sets the device level bit, 0 clears it |
| tmr_evt | input | 1 | Local timer event |
| tmr_on | input | 1 | 1 sets the timer level bit, 0 clears it |
| lvl_vec | output | 16 | Priority-level vector from the software bits |

## Verification
The bench aims at the cases where the software mask is easy to get wrong:

- Writing all ones must leave bit 16 and the low half clear. A design that used the wrong mask would show those bits in the read word.
- A clear with bit 14 alone must drop bit 31. A design that missed this link would leave level 15 raised.
- Writes to the reserved words, and writes whose address has nonzero low bits, are checked. A decoder that looked at the wrong address bits would corrupt the word.
- A device clear and a timer set aimed at the same level in the same cycle must leave the bit set. A design that ordered clear after set would drop it.
- A device event at level 0 must change nothing. A design that did not guard level 0 would set bit 0.

// File: rtl/pcpu_irq_pkg.sv
package pcpu_irq_pkg;

    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int LVL_W     = 4;
    localparam int NUM_LVL   = 1 << LVL_W;
    localparam int SOFT_BASE = 16;
    localparam logic [WORD_W-1:0] SOFT_MASK = 32'hFFFE_0000;
    localparam int TRIG15_BIT = 14;
    localparam int TOP_BIT    = WORD_W - 1;

    typedef enum logic [1:0] {
        WS_PEND = 2'd0,
        WS_CLR  = 2'd1,
        WS_SET  = 2'd2,
        WS_RSVD = 2'd3
    } word_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] set_m;
        logic [WORD_W-1:0] clr_m;
    } upd_t;

    function automatic logic [NUM_LVL-1:0] soft_to_levels(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] t;
        t = (w & SOFT_MASK) >> SOFT_BASE;
        return t[NUM_LVL-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] clr_value(input logic [WORD_W-1:0] d);
        logic [WORD_W-1:0] v;
        v = d;
        if (d[TRIG15_BIT]) v[TOP_BIT] = 1'b1;
        return v & SOFT_MASK;
    endfunction

endpackage

// File: rtl/pcpu_irq_decode.sv
module pcpu_irq_decode
    import pcpu_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] pend,
    output upd_t              bus_upd,
    output logic [WORD_W-1:0] rdata
);
    word_sel_e sel;

    always_comb begin
        sel = word_sel_e'(addr[ADDR_W-1:2]);
        bus_upd = '0;
        if (wr) begin
            case (sel)
                WS_CLR:  bus_upd.clr_m = clr_value(wdata);
                WS_SET:  bus_upd.set_m = wdata & SOFT_MASK;
                default: bus_upd = '0;
            endcase
        end
        rdata = (sel == WS_PEND) ? pend : '0;
    end
endmodule

// File: rtl/pcpu_irq_hw_merge.sv
module pcpu_irq_hw_merge
    import pcpu_irq_pkg::*;
#(
    parameter int TMR_LEVEL = 14
) (
    input  logic             dev_evt,
    input  logic [LVL_W-1:0] dev_lvl,
    input  logic             dev_on,
    input  logic             tmr_evt,
    input  logic             tmr_on,
    output upd_t             hw_upd
);
    logic [NUM_LVL-1:0] set_l, clr_l;

    assign set_l[0] = 1'b0;
    assign clr_l[0] = 1'b0;

    for (genvar l = 1; l < NUM_LVL; l++) begin : g_lvl
        logic dev_hit, tmr_hit;
        assign dev_hit  = dev_evt && (dev_lvl == LVL_W'(l));
        assign tmr_hit  = tmr_evt && (l == TMR_LEVEL);
        assign set_l[l] = (dev_hit && dev_on)  || (tmr_hit && tmr_on);
        assign clr_l[l] = (dev_hit && !dev_on) || (tmr_hit && !tmr_on);
    end

    always_comb begin
        hw_upd = '0;
        hw_upd.set_m[NUM_LVL-1:0] = set_l;
        hw_upd.clr_m[NUM_LVL-1:0] = clr_l;
    end
endmodule

// File: rtl/pcpu_irq_pend_reg.sv
module pcpu_irq_pend_reg
    import pcpu_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  upd_t              bus_upd,
    input  upd_t              hw_upd,
    output logic [WORD_W-1:0] pend
);
    logic [WORD_W-1:0] nxt;

    always_comb begin
        nxt = (pend & ~bus_upd.clr_m) | bus_upd.set_m;
        nxt = (nxt & ~hw_upd.clr_m) | hw_upd.set_m;
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= nxt;
    end
endmodule

// File: rtl/pcpu_irq_bank.sv
module pcpu_irq_bank
    import pcpu_irq_pkg::*;
#(
    parameter int TMR_LEVEL = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              dev_evt,
    input  logic [LVL_W-1:0]  dev_lvl,
    input  logic              dev_on,
    input  logic              tmr_evt,
    input  logic              tmr_on,
    output logic [NUM_LVL-1:0] lvl_vec
);
    logic [WORD_W-1:0] pend_q;
    upd_t bus_upd, hw_upd;

    pcpu_irq_decode u_dec (
        .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .pend(pend_q), .bus_upd(bus_upd), .rdata(bus_rdata)
    );

    pcpu_irq_hw_merge #(.TMR_LEVEL(TMR_LEVEL)) u_hw (
        .dev_evt(dev_evt), .dev_lvl(dev_lvl), .dev_on(dev_on),
        .tmr_evt(tmr_evt), .tmr_on(tmr_on), .hw_upd(hw_upd)
    );

    pcpu_irq_pend_reg u_reg (
        .clk(clk), .rst(rst), .bus_upd(bus_upd), .hw_upd(hw_upd), .pend(pend_q)
    );

    assign lvl_vec = soft_to_levels(pend_q);
endmodule

// File: rtl/pcpu_irq_chk.sv
module pcpu_irq_chk
    import pcpu_irq_pkg::*;
#(
    parameter int TMR_LEVEL = 14
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              tmr_evt,
    input logic              tmr_on,
    input logic [NUM_LVL-1:0] lvl_vec,
    input logic [WORD_W-1:0] pend
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (lvl_vec == '0)); // R1
    AST_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[3:2] != 2'd0) |-> (bus_rdata == '0)); // R2
    AST_SOFT_CLR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[3:2] == 2'd1 && !bus_wdata[14])
        |=> ((pend & $past(bus_wdata) & SOFT_MASK) == '0)); // R3
    AST_INT15_CLR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[3:2] == 2'd1 && bus_wdata[14]) |=> !pend[31]); // R4
    AST_SOFT_SET: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[3:2] == 2'd2)
        |=> ((pend & $past(bus_wdata) & SOFT_MASK) == ($past(bus_wdata) & SOFT_MASK))); // R5
    AST_LOW_GUARD: assert property (@(posedge clk) disable iff (rst)
        !pend[0] && !pend[16]); // R8
    AST_TMR_SET: assert property (@(posedge clk) disable iff (rst)
        (tmr_evt && tmr_on) |=> pend[TMR_LEVEL]); // R10
endmodule

bind pcpu_irq_bank pcpu_irq_chk #(.TMR_LEVEL(TMR_LEVEL)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_evt(tmr_evt),
    .tmr_on(tmr_on), .lvl_vec(lvl_vec), .pend(pend_q)
);

// File: tb/tb_pcpu_irq_bank.sv
module tb_pcpu_irq_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dev_evt = 1'b0;
    logic [3:0]  dev_lvl = '0;
    logic        dev_on = 1'b0;
    logic        tmr_evt = 1'b0;
    logic        tmr_on = 1'b0;
    logic [15:0] lvl_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pcpu_irq_bank dut (.*);

    // {address, write data, expected pending word}
    localparam int NV = 10;
    localparam logic [67:0] VEC [NV] = '{
        {4'h8, 32'hFFFF_FFFF, 32'hFFFE_0000},   // R5
        {4'h4, 32'h0002_0000, 32'hFFFC_0000},   // R3
        {4'h4, 32'h0000_4000, 32'h7FFC_0000},   // R4
        {4'h0, 32'hFFFF_FFFF, 32'h7FFC_0000},   // R6
        {4'hC, 32'hFFFF_FFFF, 32'h7FFC_0000},   // R6
        {4'h4, 32'hFFFF_FFFF, 32'h0000_0000},   // R3
        {4'h9, 32'h8001_0000, 32'h8000_0000},   // R5 R6
        {4'h6, 32'h8000_0000, 32'h0000_0000},   // R3 R6
        {4'h8, 32'hA5A5_A5A5, 32'hA5A4_0000},   // R5
        {4'h4, 32'h00A4_0000, 32'hA500_0000}    // R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = '0;
    endtask

    task automatic read_pend(input string req, input logic [31:0] exp);
        bus_addr = 4'h0;
        #1;
        check(req, bus_rdata, exp);
        check("R7", {16'h0, lvl_vec}, {16'h0, exp[31:17], 1'b0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        read_pend("R1", 32'h0);

        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i][67:64], VEC[i][63:32]);
            read_pend("R3/R4/R5/R6 vector", VEC[i][31:0]);
        end

        // R2: non-zero pending, other words read zero
        for (int w = 1; w < 4; w++) begin
            bus_addr = 4'(w << 2);
            #1;
            check("R2", bus_rdata, 32'h0);
        end
        bus_addr = 4'h0;

        // R6: strobe low, no change
        @(negedge clk);
        bus_addr = 4'h4; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_wdata = '0;
        read_pend("R6", 32'hA500_0000);

        // R8: device set and clear
        @(negedge clk);
        dev_evt = 1'b1; dev_lvl = 4'd5; dev_on = 1'b1;
        @(negedge clk);
        dev_evt = 1'b0;
        read_pend("R8", 32'hA500_0020);
        @(negedge clk);
        dev_evt = 1'b1; dev_lvl = 4'd0; dev_on = 1'b1;
        @(negedge clk);
        dev_evt = 1'b0;
        read_pend("R8", 32'hA500_0020);
        @(negedge clk);
        dev_evt = 1'b1; dev_lvl = 4'd5; dev_on = 1'b0;
        @(negedge clk);
        dev_evt = 1'b0;
        read_pend("R8", 32'hA500_0000);

        // R9: timer set and clear
        @(negedge clk);
        tmr_evt = 1'b1; tmr_on = 1'b1;
        @(negedge clk);
        tmr_evt = 1'b0;
        read_pend("R9", 32'hA500_4000);
        @(negedge clk);
        tmr_evt = 1'b1; tmr_on = 1'b0;
        @(negedge clk);
        tmr_evt = 1'b0;
        read_pend("R9", 32'hA500_0000);

        // R10: device clears 14 while timer sets 14
        @(negedge clk);
        dev_evt = 1'b1; dev_lvl = 4'd14; dev_on = 1'b0;
        tmr_evt = 1'b1; tmr_on = 1'b1;
        @(negedge clk);
        dev_evt = 1'b0; tmr_evt = 1'b0;
        read_pend("R10", 32'hA500_4000);

        // R11: bus set with device set in the same cycle
        @(negedge clk);
        bus_addr = 4'h8; bus_wr = 1'b1; bus_wdata = 32'h0002_0000;
        dev_evt = 1'b1; dev_lvl = 4'd15; dev_on = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = '0; dev_evt = 1'b0;
        read_pend("R11", 32'hA502_C000);

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_pend("R1", 32'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule